// File: doc/BRIEF.md
# Multi-Stage Watchdog Timer

A watchdog for an always-on power domain that escalates through a chain of timeout stages instead of stopping at a single expiry. Each stage has its own timeout and its own action. The action can raise an interrupt, pulse a CPU-class reset, pulse a system reset, or pulse a whole-chip reset. The three reset outputs are pulses, and each pulse length is programmed separately. The CPU-class reset fans out to six targets under a per-target mask: four application cores, the low-power core and the low-power peripherals.

Software drives the block through a simple word-addressed write/read port. All configuration and the feed strobe sit behind a write-protect key. A pause control freezes the timer while the `sleep_i` input is high.

The word address map is:

| Address | Register |
|---|---|
| 0 | CTRL |
| 1 | ACTS |
| 2 | MASK |
| 3 | FEED |
| 4 | KEY |
| 5 | IRQ_RAW |
| 6 | IRQ_CLR |
| 7 | IRQ_EN |
| 8 | IRQ_EN_SET |
| 9 | IRQ_EN_CLR |
| 12 + k | Timeout of stage k |

The CTRL fields are:

| Bits | Field |
|---|---|
| 0 | enable |
| 3:1 | CPU reset length code |
| 6:4 | system reset length code |
| 14:7 | chip reset width |
| 15 | chip reset enable |
| 16 | pause in sleep |

Top module: `stage_watchdog`

## Requirements
- R1: After reset every output is low, every register reads 0, and KEY reads 0 (locked).
- R2: Writes to CTRL, ACTS, MASK, the timeout words and FEED have no effect unless the block is unlocked. Writing 0x5A3C9E17 to KEY unlocks it and KEY then reads 1. Writing any other value to KEY locks it again.
- R3: While enabled, the active stage counts one per clock from 0. The stage fires in the cycle its count is at or above its timeout, so stage k lasts timeout+1 cycles. The next stage then starts at count 0, and stage 3 is followed by stage 0. Clearing enable returns the block to stage 0 with count 0.
- R4: Stage k takes its action from ACTS bits [3k+2:3k]. The codes are 1 = interrupt, 2 = CPU reset, 3 = system reset and 4 = chip reset. Code 0 skips the stage after one cycle without any action.
- R5: Writing FEED with bit 0 set while unlocked restarts the sequence at stage 0 with count 0, and suppresses any firing in that cycle.
- R6: With pause (CTRL bit 16) set and `sleep_i` high, the count and stage hold. With pause clear, `sleep_i` has no effect.
- R7: A firing of code 1 sets the sticky IRQ_RAW bit 0 on the following clock edge. `irq_o` is IRQ_RAW AND IRQ_EN. Writing 1 to bit 0 of IRQ_EN_SET or IRQ_EN_CLR sets or clears IRQ_EN, and writing 1 to bit 0 of IRQ_CLR clears IRQ_RAW. A set in the same cycle wins over a clear.
- R8: A firing of code 2 drives `cpu_rst_o` equal to MASK for 2^(c+1) cycles, where c is CTRL[3:1]. The pulse starts on the clock edge after the firing.
- R9: A firing of code 3 drives `sys_rst_o` high for 2^(s+1) cycles, where s is CTRL[6:4]. The pulse starts on the clock edge after the firing.
- R10: A firing of code 4 drives `chip_rst_o` high for W+1 cycles, where W is CTRL[14:7], and only when CTRL bit 15 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| sleep_i | input | 1 | Sleep indication, used for pausing |
| irq_o | output | 1 | Masked watchdog interrupt |
| cpu_rst_o | output | 6 | Per-target CPU-class reset pulses |
| sys_rst_o | output | 1 | System reset pulse |
| chip_rst_o | output | 1 | Whole-chip reset pulse |

## Verification
The assertions assume that the port is driven synchronously: at most one write per cycle, and the address and data stable around the clock edge. They also assume that `sleep_i` and the write strobe change only between edges. The bench drives every input on the falling edge and issues each write as a single-cycle strobe, so all of these hold. The bench also keeps the programmed timeouts small, so that every stage, skip and wrap is reached well within the run. A cycle-level reference model then follows every output and the selected read word on every clock.

// File: rtl/stage_wdt_pkg.sv
package stage_wdt_pkg;

   localparam int ACT_W  = 3;
   localparam int PLEN_W = 8;
   localparam int DATA_W = 32;

   typedef enum logic [ACT_W-1:0] {
      ACT_NONE = 3'd0,
      ACT_IRQ  = 3'd1,
      ACT_CPU  = 3'd2,
      ACT_SYS  = 3'd3,
      ACT_CHIP = 3'd4
   } wdt_act_e;

   typedef struct packed {
      logic       pause;
      logic       chip_en;
      logic [7:0] chip_w;
      logic [2:0] sys_code;
      logic [2:0] cpu_code;
      logic       en;
   } wdt_ctrl_t;

   localparam int CTRL_W = $bits(wdt_ctrl_t);

   localparam int A_CTRL    = 0;
   localparam int A_ACTS    = 1;
   localparam int A_MASK    = 2;
   localparam int A_FEED    = 3;
   localparam int A_KEY     = 4;
   localparam int A_RAW     = 5;
   localparam int A_CLR     = 6;
   localparam int A_IEN     = 7;
   localparam int A_IEN_SET = 8;
   localparam int A_IEN_CLR = 9;
   localparam int A_TO_BASE = 12;

   // Pulse length minus one for a 2^(code+1) cycle pulse.
   function automatic logic [PLEN_W-1:0] pulse_len(input logic [2:0] code);
      logic [PLEN_W:0] n;
      n = (PLEN_W+1)'(1) << ({1'b0, code} + 4'd1);
      return PLEN_W'(n - (PLEN_W+1)'(1));
   endfunction

endpackage

// File: rtl/stage_wdt_pulse.sv
module stage_wdt_pulse #(
   parameter int LEN_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             active_o
);

   logic [LEN_W-1:0] left_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         left_q   <= '0;
         active_o <= 1'b0;
      end else if (start_i) begin
         left_q   <= len_i;
         active_o <= 1'b1;
      end else if (active_o) begin
         if (left_q == '0) active_o <= 1'b0;
         else              left_q   <= left_q - 1'b1;
      end
   end

   // R8 R9 R10: a pulse only begins after a start request
   a_r8_rise_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(active_o) |-> $past(start_i));

endmodule

// File: rtl/stage_wdt_seq.sv
module stage_wdt_seq import stage_wdt_pkg::*; #(
   parameter int STAGES = 4,
   parameter int CNT_W  = 32
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    en_i,
   input  logic                    pause_i,
   input  logic                    sleep_i,
   input  logic                    feed_i,
   input  logic [STAGES*ACT_W-1:0] acts_i,
   input  logic [CNT_W-1:0]        to_i [STAGES],
   output logic                    fire_o,
   output logic [ACT_W-1:0]        act_o
);

   localparam int SW = (STAGES > 1) ? $clog2(STAGES) : 1;

   if (STAGES < 2 || (1 << SW) != STAGES) begin : g_bad_stages
      $error("STAGES must be a power of two of at least 2");
   end

   logic [SW-1:0]    stage_q;
   logic [CNT_W-1:0] cnt_q;
   logic             paused;

   assign paused = pause_i && sleep_i;
   assign act_o  = acts_i[stage_q*ACT_W +: ACT_W];
   assign fire_o = en_i && !feed_i && !paused && (act_o != ACT_NONE)
                   && (cnt_q >= to_i[stage_q]);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stage_q <= '0;
         cnt_q   <= '0;
      end else if (!en_i || feed_i) begin
         stage_q <= '0;
         cnt_q   <= '0;
      end else if (!paused) begin
         if (fire_o || act_o == ACT_NONE) begin
            stage_q <= stage_q + 1'b1;
            cnt_q   <= '0;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   // R3: a firing moves to the next stage, wrapping after the last
   a_r3_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |=> stage_q == SW'($past(stage_q) + 1'b1));

   // R4: a disabled stage is left with a cleared count
   a_r4_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !feed_i && !paused && act_o == ACT_NONE) |=> cnt_q == '0);

   // R5: feeding restarts at stage 0
   a_r5_feed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      feed_i |=> (cnt_q == '0 && stage_q == '0));

   // R6: pause while sleeping freezes the sequencer
   a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && paused && !feed_i) |=> ($stable(cnt_q) && $stable(stage_q)));

endmodule

// File: rtl/stage_wdt_regs.sv
module stage_wdt_regs import stage_wdt_pkg::*; #(
   parameter int          STAGES = 4,
   parameter int          CNT_W  = 32,
   parameter int          ADDR_W = 5,
   parameter int          TGT_W  = 6,
   parameter logic [31:0] KEY    = 32'h5A3C_9E17
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    we_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [DATA_W-1:0]       wdata_i,
   output logic [DATA_W-1:0]       rdata_o,
   input  logic                    irq_set_i,
   output wdt_ctrl_t               ctrl_o,
   output logic [STAGES*ACT_W-1:0] acts_o,
   output logic [TGT_W-1:0]        mask_o,
   output logic [CNT_W-1:0]        to_o [STAGES],
   output logic                    feed_o,
   output logic                    irq_o
);

   localparam int AW_ACT = STAGES * ACT_W;

   if (AW_ACT > DATA_W || CNT_W > DATA_W || TGT_W > DATA_W) begin : g_bad_width
      $error("register fields must fit in one data word");
   end
   if (A_TO_BASE + STAGES > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the timeout words");
   end

   logic unl_q, raw_q, ien_q, wr_cfg, clr_raw;
   logic unused_wdata;

   assign unused_wdata = ^wdata_i;
   assign wr_cfg  = we_i && unl_q;
   assign clr_raw = we_i && addr_i == ADDR_W'(A_CLR) && wdata_i[0];
   assign feed_o  = wr_cfg && addr_i == ADDR_W'(A_FEED) && wdata_i[0];
   assign irq_o   = raw_q && ien_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_o <= '0;
         acts_o <= '0;
         mask_o <= '0;
         unl_q  <= 1'b0;
         raw_q  <= 1'b0;
         ien_q  <= 1'b0;
      end else begin
         raw_q <= irq_set_i || (raw_q && !clr_raw);
         if (wr_cfg && addr_i == ADDR_W'(A_CTRL)) ctrl_o <= wdt_ctrl_t'(wdata_i[CTRL_W-1:0]);
         if (wr_cfg && addr_i == ADDR_W'(A_ACTS)) acts_o <= wdata_i[AW_ACT-1:0];
         if (wr_cfg && addr_i == ADDR_W'(A_MASK)) mask_o <= wdata_i[TGT_W-1:0];
         if (we_i && addr_i == ADDR_W'(A_KEY))    unl_q  <= (wdata_i == KEY);
         if (we_i && addr_i == ADDR_W'(A_IEN))    ien_q  <= wdata_i[0];
         else if (we_i && addr_i == ADDR_W'(A_IEN_SET) && wdata_i[0]) ien_q <= 1'b1;
         else if (we_i && addr_i == ADDR_W'(A_IEN_CLR) && wdata_i[0]) ien_q <= 1'b0;
      end
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_to
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) to_o[k] <= '0;
         else if (wr_cfg && addr_i == ADDR_W'(A_TO_BASE + k)) to_o[k] <= wdata_i[CNT_W-1:0];
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(A_CTRL)) rdata_o = DATA_W'(ctrl_o);
      if (addr_i == ADDR_W'(A_ACTS)) rdata_o = DATA_W'(acts_o);
      if (addr_i == ADDR_W'(A_MASK)) rdata_o = DATA_W'(mask_o);
      if (addr_i == ADDR_W'(A_KEY))  rdata_o = DATA_W'(unl_q);
      if (addr_i == ADDR_W'(A_RAW))  rdata_o = DATA_W'(raw_q);
      if (addr_i == ADDR_W'(A_IEN))  rdata_o = DATA_W'(ien_q);
      for (int k = 0; k < STAGES; k++)
         if (addr_i == ADDR_W'(A_TO_BASE + k)) rdata_o = DATA_W'(to_o[k]);
   end

   // R2: a locked control write leaves the control word unchanged
   a_r2_locked_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(A_CTRL) && !unl_q) |=> $stable(ctrl_o));

   // R7: the raw interrupt bit stays set until cleared
   a_r7_raw_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raw_q && !clr_raw) |=> raw_q);

endmodule

// File: rtl/stage_watchdog.sv
module stage_watchdog import stage_wdt_pkg::*; #(
   parameter int          STAGES = 4,
   parameter int          CNT_W  = 32,
   parameter int          ADDR_W = 5,
   parameter int          TGT_W  = 6,
   parameter logic [31:0] KEY    = 32'h5A3C_9E17
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   input  logic              sleep_i,
   output logic              irq_o,
   output logic [TGT_W-1:0]  cpu_rst_o,
   output logic              sys_rst_o,
   output logic              chip_rst_o
);

   localparam int NPULSE = 3;

   wdt_ctrl_t               ctrl;
   logic [STAGES*ACT_W-1:0] acts;
   logic [TGT_W-1:0]        mask;
   logic [CNT_W-1:0]        to_v [STAGES];
   logic                    feed, fire;
   logic [ACT_W-1:0]        act;
   logic [NPULSE-1:0]       p_start, p_act;
   logic [PLEN_W-1:0]       p_len [NPULSE];

   stage_wdt_regs #(.STAGES(STAGES), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
                    .TGT_W(TGT_W), .KEY(KEY)) u_regs (
      .clk_i, .rst_ni,
      .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
      .rdata_o(reg_rdata_o),
      .irq_set_i(fire && act == ACT_IRQ),
      .ctrl_o(ctrl), .acts_o(acts), .mask_o(mask), .to_o(to_v),
      .feed_o(feed), .irq_o(irq_o)
   );

   stage_wdt_seq #(.STAGES(STAGES), .CNT_W(CNT_W)) u_seq (
      .clk_i, .rst_ni,
      .en_i(ctrl.en), .pause_i(ctrl.pause), .sleep_i(sleep_i), .feed_i(feed),
      .acts_i(acts), .to_i(to_v), .fire_o(fire), .act_o(act)
   );

   assign p_start[0] = fire && act == ACT_CPU;
   assign p_start[1] = fire && act == ACT_SYS;
   assign p_start[2] = fire && act == ACT_CHIP && ctrl.chip_en;
   assign p_len[0]   = pulse_len(ctrl.cpu_code);
   assign p_len[1]   = pulse_len(ctrl.sys_code);
   assign p_len[2]   = ctrl.chip_w;

   for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
      stage_wdt_pulse #(.LEN_W(PLEN_W)) u_pulse (
         .clk_i, .rst_ni,
         .start_i(p_start[g]), .len_i(p_len[g]), .active_o(p_act[g])
      );
   end

   assign cpu_rst_o  = {TGT_W{p_act[0]}} & mask;
   assign sys_rst_o  = p_act[1];
   assign chip_rst_o = p_act[2];

   // R10: a chip pulse only starts while the chip reset is enabled
   a_r10_chip_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(chip_rst_o) |-> $past(ctrl.chip_en));

endmodule

// File: tb/stage_watchdog_test.sv
module stage_watchdog_test;

   localparam logic [31:0] KEY = 32'h5A3C_9E17;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        we = 1'b0, sleep = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_o, sys_rst_o, chip_rst_o;
   logic [5:0]  cpu_rst_o;

   int checks = 0, failures = 0, cycles = 0;
   string phase = "R1";

   always #2 clk = ~clk;

   stage_watchdog uut (
      .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sleep_i(sleep),
      .irq_o(irq_o), .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o),
      .chip_rst_o(chip_rst_o)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [16:0] m_ctrl;
   logic [11:0] m_acts;
   logic [5:0]  m_mask;
   logic [31:0] m_to [4];
   bit          m_unl, m_raw, m_ien;
   int          m_stage, cpu_left, sys_left, chip_left;
   longint      m_cnt;

   function automatic logic [31:0] exp_rd(input logic [4:0] a);
      case (a)
         5'd0: return 32'(m_ctrl);
         5'd1: return 32'(m_acts);
         5'd2: return 32'(m_mask);
         5'd4: return 32'(m_unl);
         5'd5: return 32'(m_raw);
         5'd7: return 32'(m_ien);
         5'd12, 5'd13, 5'd14, 5'd15: return m_to[a - 5'd12];
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = '0; m_acts = '0; m_mask = '0; m_unl = 0; m_raw = 0; m_ien = 0;
         for (int k = 0; k < 4; k++) m_to[k] = '0;
         m_stage = 0; m_cnt = 0; cpu_left = 0; sys_left = 0; chip_left = 0;
      end else begin
         bit paused, feed, fire;
         int code;
         paused = m_ctrl[16] && sleep;
         feed   = m_unl && we && addr == 5'd3 && wdata[0];
         code   = int'(m_acts[m_stage*3 +: 3]);
         fire   = m_ctrl[0] && !feed && !paused && code != 0 && m_cnt >= longint'(m_to[m_stage]);
         if (cpu_left > 0) cpu_left--;
         if (sys_left > 0) sys_left--;
         if (chip_left > 0) chip_left--;
         if (fire && code == 2) cpu_left = 2 ** (int'(m_ctrl[3:1]) + 1);
         if (fire && code == 3) sys_left = 2 ** (int'(m_ctrl[6:4]) + 1);
         if (fire && code == 4 && m_ctrl[15]) chip_left = int'(m_ctrl[14:7]) + 1;
         if (fire && code == 1) m_raw = 1;
         else if (we && addr == 5'd6 && wdata[0]) m_raw = 0;
         if (!m_ctrl[0] || feed) begin m_stage = 0; m_cnt = 0; end
         else if (!paused) begin
            if (fire || code == 0) begin m_stage = (m_stage + 1) % 4; m_cnt = 0; end
            else m_cnt++;
         end
         if (we) begin
            if (m_unl) begin
               if (addr == 5'd0) m_ctrl = wdata[16:0];
               if (addr == 5'd1) m_acts = wdata[11:0];
               if (addr == 5'd2) m_mask = wdata[5:0];
               if (addr >= 5'd12 && addr <= 5'd15) m_to[addr - 5'd12] = wdata;
            end
            if (addr == 5'd4) m_unl = (wdata == KEY);
            if (addr == 5'd7) m_ien = wdata[0];
            else if (addr == 5'd8 && wdata[0]) m_ien = 1;
            else if (addr == 5'd9 && wdata[0]) m_ien = 0;
         end
      end
      #1;
      cycles++;
      chk(irq_o == (m_raw && m_ien), {phase, " irq_o"}, irq_o, m_raw && m_ien);
      chk(cpu_rst_o == (cpu_left > 0 ? m_mask : 6'd0), {phase, " cpu_rst_o"}, cpu_rst_o,
          cpu_left > 0 ? m_mask : 6'd0);
      chk(sys_rst_o == (sys_left > 0), {phase, " sys_rst_o"}, sys_rst_o, sys_left > 0);
      chk(chip_rst_o == (chip_left > 0), {phase, " chip_rst_o"}, chip_rst_o, chip_left > 0);
      chk(rdata == exp_rd(addr), {phase, " rdata"}, rdata, exp_rd(addr));
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0; wdata = '0;
   endtask

   task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); addr = a;
      @(posedge clk); #1;
      chk(rdata == exp, tag, rdata, exp);
   endtask

   function automatic bit sig(input int which);
      if (which == 0) return |cpu_rst_o;
      if (which == 1) return sys_rst_o;
      return chip_rst_o;
   endfunction

   task automatic width_of(input int which, output int w, output logic [5:0] v);
      int guard = 0;
      w = 0;
      do begin @(posedge clk); #1; guard++; end while (!sig(which) && guard < 200);
      v = cpu_rst_o;
      while (sig(which) && w < 600) begin w++; @(posedge clk); #1; end
   endtask

   initial begin : watchdog
      wait (cycles > 20000);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int w, n;
      logic [5:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      @(posedge clk); #1;
      chk(rdata == 0 && irq_o == 0 && cpu_rst_o == 0, "R1 reset outputs", rdata, 0);
      rd_chk(5'd4, 32'd0, "R1 KEY locked");

      phase = "R2";
      wr(5'd0, 32'h1);
      rd_chk(5'd0, 32'd0, "R2 locked CTRL write");
      wr(5'd4, KEY);
      rd_chk(5'd4, 32'd1, "R2 unlocked");
      wr(5'd2, 32'h25);
      rd_chk(5'd2, 32'h25, "R2 MASK written");
      wr(5'd4, 32'h1234);
      wr(5'd2, 32'h3F);
      rd_chk(5'd2, 32'h25, "R2 relocked MASK held");
      wr(5'd4, KEY);

      // R3 R8 R9 R10: irq, cpu, sys, chip stages
      phase = "R3";
      wr(5'd1, 32'h8D1);
      wr(5'd12, 32'd5); wr(5'd13, 32'd3); wr(5'd14, 32'd4); wr(5'd15, 32'd2);
      wr(5'd8, 32'd1);
      wr(5'd0, 32'h8183);
      n = 0;
      do begin @(posedge clk); #1; n++; end while (!irq_o && n < 50);
      chk(n == 6, "R3 first stage fires after timeout+1", n, 6);
      phase = "R8";
      width_of(0, w, v);
      chk(w == 4, "R8 cpu pulse width", w, 4);
      chk(v == 6'h25, "R8 cpu pulse mask", v, 6'h25);
      phase = "R9";
      width_of(1, w, v);
      chk(w == 2, "R9 sys pulse width", w, 2);
      phase = "R10";
      width_of(2, w, v);
      chk(w == 4, "R10 chip pulse width", w, 4);
      phase = "R3";
      repeat (40) @(negedge clk);

      phase = "R7";
      wr(5'd9, 32'd1);
      @(posedge clk); #1;
      chk(irq_o == 0, "R7 irq masked", irq_o, 0);
      rd_chk(5'd5, 32'd1, "R7 raw sticky");
      wr(5'd0, 32'h8182);
      wr(5'd6, 32'd1);
      rd_chk(5'd5, 32'd0, "R7 raw cleared");
      wr(5'd8, 32'd1);
      rd_chk(5'd7, 32'd1, "R7 enable set alias");

      phase = "R5";
      wr(5'd1, 32'h1);
      wr(5'd12, 32'd10);
      wr(5'd0, 32'h8183);
      for (int i = 0; i < 8; i++) begin
         repeat (6) @(negedge clk);
         wr(5'd3, 32'd1);
      end
      rd_chk(5'd5, 32'd0, "R5 feeding prevents firing");
      phase = "R2";
      wr(5'd4, 32'd0);
      for (int i = 0; i < 3; i++) begin
         repeat (4) @(negedge clk);
         wr(5'd3, 32'd1);
      end
      rd_chk(5'd5, 32'd1, "R2 locked feed ignored");
      wr(5'd4, KEY);

      phase = "R4";
      wr(5'd0, 32'h8182);
      wr(5'd6, 32'd1);
      wr(5'd1, 32'h40);
      wr(5'd12, 32'd2); wr(5'd13, 32'd2); wr(5'd14, 32'd2); wr(5'd15, 32'd2);
      wr(5'd0, 32'h8183);
      n = 0;
      do begin @(posedge clk); #1; n++; end while (!irq_o && n < 50);
      chk(n == 5, "R4 two skipped stages then irq", n, 5);

      phase = "R6";
      wr(5'd0, 32'h8182);
      wr(5'd6, 32'd1);
      wr(5'd1, 32'h1);
      wr(5'd12, 32'd3);
      sleep = 1'b1;
      wr(5'd0, 32'h18183);
      repeat (20) @(posedge clk);
      #1;
      chk(irq_o == 0, "R6 paused during sleep", irq_o, 0);
      wr(5'd0, 32'h8183);
      repeat (8) @(posedge clk);
      #1;
      chk(irq_o == 1, "R6 sleep ignored without pause", irq_o, 1);
      sleep = 1'b0;

      phase = "R10";
      wr(5'd0, 32'h8182);
      wr(5'd6, 32'd1);
      wr(5'd1, 32'h4);
      wr(5'd12, 32'd1);
      wr(5'd0, 32'h0183);
      n = 0;
      for (int i = 0; i < 30; i++) begin
         @(posedge clk); #1;
         if (chip_rst_o) n++;
      end
      chk(n == 0, "R10 chip reset gated off", n, 0);

      phase = "R3";
      wr(5'd0, 32'h0);
      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule